// File: doc/BRIEF.md
# Edge-Streamed Neighbour Aggregator

This block carries out the neighbour-summing stage of one graph convolution layer. The transformed feature vector of every node is written into an on-chip feature store that allows random access. A per-feature bias vector is loaded into a small register file. Weighted edges then arrive one at a time as (source, destination, weight) triples and are not kept on chip. For each edge, the source row is read, every feature is multiplied by the signed edge weight, and the products are added into the destination row of an accumulator store. An edge retires only after all feature slices of its destination row have been updated. Self-loops are ordinary edges with source equal to destination.

Features are handled SIMD lanes at a time. A row of N_FEAT features is split into BEATS = N_FEAT/SIMD slices, and each edge occupies BEATS consecutive cycles. Parallel work is spread only across features and never across edges, so two edges never touch the accumulator store in the same cycle. The edge stream must already be ordered so that two consecutive edges never share a destination. With that ordering, the read-modify-write pipeline needs no hazard logic.

After the last edge, a graph-end pulse gives the number of rows to emit. The block waits for the pipeline to empty. It then streams the rows out in row-major order, applying bias-add and ReLU on the way and clearing each accumulator word as it is read out. A last flag marks the final output beat. No new edge is taken until the output has drained.

Top module: `edge_aggregator`

## Requirements
- R1: While reset is high and for exactly N_NODES*BEATS cycles after it falls, edge_ready stays low while the accumulator store is cleared. edge_ready then rises, and out_valid stays low throughout.
- R2: For row n and feature f, the output element is max(0, bias[f] + sum over accepted edges with dst=n of wt*x[src][f]). All values are signed two's complement (features and bias DW bits, weight WW bits), products are kept at full precision, and accumulators are AW = DW+WW+GW bits wide.
- R3: An accepted edge occupies BEATS cycles. With edges offered back to back, consecutive acceptances are exactly BEATS cycles apart.
- R4: After graph_end with graph_rows = R ≥ 1, the block emits exactly R*BEATS beats on consecutive cycles, with no gaps. The rows come in ascending order with slices in ascending order. Lane j of slice b of row r carries feature b*SIMD+j in out_data bits [j*OW +: OW], with OW = AW+1.
- R5: out_last is high on the final beat of a drain and on no other beat.
- R6: Any element whose biased sum is negative is output as zero, so the top bit of every output lane is zero.
- R7: Each drained row's accumulators are cleared, so a following graph starts from zero sums.
- R8: edge_ready is low from the cycle after graph_end is accepted until the cycle after the out_last beat.
- R9: Two consecutively accepted edges of one graph never share a destination. This is an input contract, and the block gives correct sums when same-destination edges are separated by a single other edge.
- R10: A drained row with no incoming edges outputs max(0, bias[f]). Features are written as slices with feat_node and feat_beat, and bias slices with bias_beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| feat_we | input | 1 | Write one feature slice |
| feat_node | input | NIW | Node row of the slice |
| feat_beat | input | BW | Slice index within the row |
| feat_data | input | SIMD*DW | SIMD signed features, lane j at [j*DW +: DW] |
| bias_we | input | 1 | Write one bias slice |
| bias_beat | input | BW | Bias slice index |
| bias_data | input | SIMD*DW | SIMD signed bias values |
| edge_valid | input | 1 | Edge offered |
| edge_ready | output | 1 | Edge accepted when valid and ready |
| edge_src | input | NIW | Source node |
| edge_dst | input | NIW | Destination node |
| edge_wt | input | WW | Signed edge coefficient |
| graph_end | input | 1 | Pulse after the last edge of a graph |
| graph_rows | input | RW | Number of rows to emit, sampled with graph_end |
| out_valid | output | 1 | Output beat valid |
| out_data | output | SIMD*OW | SIMD non-negative results |
| out_last | output | 1 | Final beat of the drain |

## Verification
The bench builds the block with six nodes, six features and two lanes, so each edge spans three slices. It also uses 8-bit features and weights with four guard bits. At this size, every row and slice of every graph can be checked against sums computed in the bench. These include a lone one-node graph, nodes with no edges, sums forced negative through the ReLU, and sums of repeated -128 × -128 products near the accumulator range. A pseudo-random sweep of forty graphs of one to six rows varies the edge counts and weights. Alongside it, a repeated graph shows that the drain clears the accumulators, and a minimally spaced same-destination ordering exercises the hazard contract at its tightest legal point.

// File: rtl/agg_pkg.sv
package agg_pkg;
  typedef enum logic [1:0] {
    ST_CLR   = 2'd0,
    ST_AGG   = 2'd1,
    ST_DRAIN = 2'd2
  } agg_state_e;
endpackage

// File: rtl/agg_ram.sv
module agg_ram #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AAW  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk,
  input  logic           we,
  input  logic [AAW-1:0] waddr,
  input  logic [W-1:0]   wdata,
  input  logic [AAW-1:0] raddr,
  output logic [W-1:0]   rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/agg_mac_lanes.sv
module agg_mac_lanes #(
  parameter int SIMD = 4,
  parameter int DW   = 8,
  parameter int WW   = 8,
  parameter int AW   = 20
) (
  input  logic [SIMD*DW-1:0]   feat_word,
  input  logic [SIMD*AW-1:0]   acc_word,
  input  logic signed [WW-1:0] wt,
  output logic [SIMD*AW-1:0]   sum_word
);
  localparam int PW = DW + WW;

  for (genvar j = 0; j < SIMD; j++) begin : g_lane
    logic signed [DW-1:0] x;
    logic signed [AW-1:0] a;
    logic signed [PW-1:0] p;
    assign x = feat_word[j*DW +: DW];
    assign a = acc_word[j*AW +: AW];
    assign p = x * wt;
    assign sum_word[j*AW +: AW] = a + AW'(p);
  end
endmodule

// File: rtl/agg_out_lanes.sv
module agg_out_lanes #(
  parameter int SIMD = 4,
  parameter int DW   = 8,
  parameter int AW   = 20,
  parameter int OW   = 21
) (
  input  logic [SIMD*AW-1:0] acc_word,
  input  logic [SIMD*DW-1:0] bias_word,
  output logic [SIMD*OW-1:0] res_word
);
  for (genvar j = 0; j < SIMD; j++) begin : g_lane
    logic signed [AW-1:0] a;
    logic signed [DW-1:0] b;
    logic signed [OW-1:0] s;
    assign a = acc_word[j*AW +: AW];
    assign b = bias_word[j*DW +: DW];
    assign s = OW'(a) + OW'(b);
    assign res_word[j*OW +: OW] = s[OW-1] ? '0 : s;
  end
endmodule

// File: rtl/edge_aggregator.sv
module edge_aggregator #(
  parameter int N_NODES = 8,
  parameter int N_FEAT  = 8,
  parameter int SIMD    = 4,
  parameter int DW      = 8,
  parameter int WW      = 8,
  parameter int GW      = 4,
  localparam int BEATS  = N_FEAT / SIMD,
  localparam int DEPTH  = N_NODES * BEATS,
  localparam int AAW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int NIW    = (N_NODES > 1) ? $clog2(N_NODES) : 1,
  localparam int BW     = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int RW     = $clog2(N_NODES + 1),
  localparam int AW     = DW + WW + GW,
  localparam int OW     = AW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 feat_we,
  input  logic [NIW-1:0]       feat_node,
  input  logic [BW-1:0]        feat_beat,
  input  logic [SIMD*DW-1:0]   feat_data,
  input  logic                 bias_we,
  input  logic [BW-1:0]        bias_beat,
  input  logic [SIMD*DW-1:0]   bias_data,
  input  logic                 edge_valid,
  output logic                 edge_ready,
  input  logic [NIW-1:0]       edge_src,
  input  logic [NIW-1:0]       edge_dst,
  input  logic signed [WW-1:0] edge_wt,
  input  logic                 graph_end,
  input  logic [RW-1:0]        graph_rows,
  output logic                 out_valid,
  output logic [SIMD*OW-1:0]   out_data,
  output logic                 out_last
);
  import agg_pkg::*;

  function automatic logic [AAW-1:0] row_addr(input logic [NIW-1:0] n, input logic [BW-1:0] b);
    return AAW'(n) * AAW'(BEATS) + AAW'(b);
  endfunction

  agg_state_e          st;
  logic [AAW-1:0]      clr_cnt;
  logic                done_req;
  logic [RW-1:0]       rows_q;

  // edge being expanded into slices
  logic                er_valid;
  logic [NIW-1:0]      er_src, er_dst;
  logic signed [WW-1:0] er_wt;
  logic [BW-1:0]       er_beat;

  // drain counters
  logic [NIW-1:0]      dr_row;
  logic [BW-1:0]       dr_beat;
  logic                drn_last;

  // read-data stage
  logic                p_valid, p_drain, p_last;
  logic [AAW-1:0]      p_addr;
  logic [BW-1:0]       p_beat;
  logic signed [WW-1:0] p_wt;

  logic [SIMD*DW-1:0]  bias_q [BEATS];

  logic                iss_agg, iss_drn, accept, er_end;
  logic [AAW-1:0]      feat_raddr, acc_raddr, acc_waddr;
  logic                acc_we;
  logic [SIMD*AW-1:0]  acc_wdata, acc_rdata, mac_sum;
  logic [SIMD*DW-1:0]  feat_rdata;
  logic [SIMD*OW-1:0]  res_word;

  assign er_end   = (er_beat == BW'(BEATS - 1));
  assign drn_last = (RW'(dr_row) + RW'(1) == rows_q) && (dr_beat == BW'(BEATS - 1));
  assign edge_ready = (st == ST_AGG) && !done_req && !(p_valid && p_drain) && !out_valid
                      && (!er_valid || er_end);
  assign accept   = edge_valid && edge_ready;
  assign iss_agg  = (st == ST_AGG) && er_valid;
  assign iss_drn  = (st == ST_DRAIN);

  assign feat_raddr = row_addr(er_src, er_beat);
  assign acc_raddr  = iss_drn ? row_addr(dr_row, dr_beat) : row_addr(er_dst, er_beat);

  assign acc_we    = (st == ST_CLR) || p_valid;
  assign acc_waddr = (st == ST_CLR) ? clr_cnt : p_addr;
  assign acc_wdata = ((st == ST_CLR) || p_drain) ? '0 : mac_sum;

  agg_ram #(.W(SIMD*DW), .DEPTH(DEPTH)) u_feat (
    .clk(clk), .we(feat_we), .waddr(row_addr(feat_node, feat_beat)), .wdata(feat_data),
    .raddr(feat_raddr), .rdata(feat_rdata)
  );

  agg_ram #(.W(SIMD*AW), .DEPTH(DEPTH)) u_acc (
    .clk(clk), .we(acc_we), .waddr(acc_waddr), .wdata(acc_wdata),
    .raddr(acc_raddr), .rdata(acc_rdata)
  );

  agg_mac_lanes #(.SIMD(SIMD), .DW(DW), .WW(WW), .AW(AW)) u_mac (
    .feat_word(feat_rdata), .acc_word(acc_rdata), .wt(p_wt), .sum_word(mac_sum)
  );

  agg_out_lanes #(.SIMD(SIMD), .DW(DW), .AW(AW), .OW(OW)) u_out (
    .acc_word(acc_rdata), .bias_word(bias_q[p_beat]), .res_word(res_word)
  );

  always_ff @(posedge clk) begin
    if (bias_we) bias_q[bias_beat] <= bias_data;
  end

  // control state
  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_CLR;
      clr_cnt  <= '0;
      done_req <= 1'b0;
      rows_q   <= '0;
      dr_row   <= '0;
      dr_beat  <= '0;
    end else begin
      case (st)
        ST_CLR: begin
          clr_cnt <= clr_cnt + AAW'(1);
          if (clr_cnt == AAW'(DEPTH - 1)) st <= ST_AGG;
        end
        ST_AGG: begin
          if (graph_end && !done_req) begin
            done_req <= 1'b1;
            rows_q   <= graph_rows;
          end
          if (done_req && !er_valid && !p_valid) begin
            if (rows_q == '0) begin
              done_req <= 1'b0;
            end else begin
              st      <= ST_DRAIN;
              dr_row  <= '0;
              dr_beat <= '0;
            end
          end
        end
        ST_DRAIN: begin
          if (drn_last) begin
            st       <= ST_AGG;
            done_req <= 1'b0;
          end else if (dr_beat == BW'(BEATS - 1)) begin
            dr_beat <= '0;
            dr_row  <= dr_row + NIW'(1);
          end else begin
            dr_beat <= dr_beat + BW'(1);
          end
        end
        default: st <= ST_CLR;
      endcase
    end
  end

  // edge slicing
  always_ff @(posedge clk) begin
    if (rst) begin
      er_valid <= 1'b0;
      er_beat  <= '0;
      er_src   <= '0;
      er_dst   <= '0;
      er_wt    <= '0;
    end else if (accept) begin
      er_valid <= 1'b1;
      er_beat  <= '0;
      er_src   <= edge_src;
      er_dst   <= edge_dst;
      er_wt    <= edge_wt;
    end else if (er_valid) begin
      if (er_end) er_valid <= 1'b0;
      else        er_beat  <= er_beat + BW'(1);
    end
  end

  // read-data stage and registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      p_valid   <= 1'b0;
      p_drain   <= 1'b0;
      p_last    <= 1'b0;
      p_addr    <= '0;
      p_beat    <= '0;
      p_wt      <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
    end else begin
      p_valid   <= iss_agg || iss_drn;
      p_drain   <= iss_drn;
      p_last    <= iss_drn && drn_last;
      p_addr    <= acc_raddr;
      p_beat    <= iss_drn ? dr_beat : er_beat;
      p_wt      <= er_wt;
      out_valid <= p_valid && p_drain;
      out_last  <= p_valid && p_drain && p_last;
      out_data  <= res_word;
    end
  end
endmodule

// File: rtl/agg_checker.sv
module agg_checker #(
  parameter int NIW  = 3,
  parameter int SIMD = 4,
  parameter int OW   = 21
) (
  input logic               clk,
  input logic               rst,
  input logic               edge_valid,
  input logic               edge_ready,
  input logic [NIW-1:0]     edge_dst,
  input logic               graph_end,
  input logic               out_valid,
  input logic               out_last,
  input logic [SIMD*OW-1:0] out_data
);
  logic           have_last;
  logic [NIW-1:0] last_dst;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_last <= 1'b0;
      last_dst  <= '0;
    end else if (graph_end) begin
      have_last <= 1'b0;
    end else if (edge_valid && edge_ready) begin
      have_last <= 1'b1;
      last_dst  <= edge_dst;
    end
  end

  AST_DST_GAP: assert property (@(posedge clk) disable iff (rst)
    (edge_valid && edge_ready && have_last) |-> (edge_dst != last_dst)); // R9

  AST_END_BLOCKS_EDGES: assert property (@(posedge clk) disable iff (rst)
    (graph_end && edge_ready) |=> !edge_ready); // R8

  AST_NO_EDGE_WHILE_OUT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !edge_ready); // R8

  AST_LAST_IS_VALID: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid); // R5

  AST_BURST_GAPLESS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |=> out_valid); // R4

  for (genvar j = 0; j < SIMD; j++) begin : g_relu
    AST_LANE_NONNEG: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> !out_data[j*OW + OW - 1]); // R6
  end
endmodule

bind edge_aggregator agg_checker #(.NIW(NIW), .SIMD(SIMD), .OW(OW)) u_chk (
  .clk(clk), .rst(rst), .edge_valid(edge_valid), .edge_ready(edge_ready),
  .edge_dst(edge_dst), .graph_end(graph_end), .out_valid(out_valid),
  .out_last(out_last), .out_data(out_data)
);

// File: tb/sim_edge_aggregator.sv
module sim_edge_aggregator;
  localparam int NN = 6, NF = 6, SIMD = 2, DW = 8, WW = 8, GW = 4;
  localparam int BEATS = NF / SIMD, DEPTH = NN * BEATS;
  localparam int NIW = 3, BW = 2, RW = 3, AW = DW + WW + GW, OW = AW + 1;
  localparam int MAXE = 64;

  logic clk = 1'b0, rst = 1'b1;
  logic feat_we = 0, bias_we = 0, edge_valid = 0, graph_end = 0;
  logic [NIW-1:0] feat_node = '0, edge_src = '0, edge_dst = '0;
  logic [BW-1:0] feat_beat = '0, bias_beat = '0;
  logic [SIMD*DW-1:0] feat_data = '0, bias_data = '0;
  logic signed [WW-1:0] edge_wt = '0;
  logic [RW-1:0] graph_rows = '0;
  logic edge_ready, out_valid, out_last;
  logic [SIMD*OW-1:0] out_data;

  always #5 clk = ~clk;

  edge_aggregator #(.N_NODES(NN), .N_FEAT(NF), .SIMD(SIMD), .DW(DW), .WW(WW), .GW(GW)) u0 (
    .clk(clk), .rst(rst), .feat_we(feat_we), .feat_node(feat_node), .feat_beat(feat_beat),
    .feat_data(feat_data), .bias_we(bias_we), .bias_beat(bias_beat), .bias_data(bias_data),
    .edge_valid(edge_valid), .edge_ready(edge_ready), .edge_src(edge_src), .edge_dst(edge_dst),
    .edge_wt(edge_wt), .graph_end(graph_end), .graph_rows(graph_rows), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last)
  );

  int total = 0, bad = 0;
  int cyc = 0;
  int feat [NN][NF];
  int bias [NF];
  int es [MAXE], ed [MAXE], ew [MAXE];
  int ne = 0;
  int got [NN*BEATS][SIMD];
  bit got_last [NN*BEATS];
  int n_got = 0;
  int first_acc, last_acc, n_acc;
  int unsigned seed = 32'h1234abcd;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (out_valid && n_got < NN*BEATS) begin
      for (int j = 0; j < SIMD; j++) got[n_got][j] = int'(out_data[j*OW +: OW]);
      got_last[n_got] = out_last;
      n_got = n_got + 1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int rnd(input int lo, input int hi);
    seed = seed * 32'd1103515245 + 32'd12345;
    return lo + int'((seed >> 16) % (hi - lo + 1));
  endfunction

  task automatic load_all();
    for (int n = 0; n < NN; n++)
      for (int b = 0; b < BEATS; b++) begin
        feat_we = 1; feat_node = NIW'(n); feat_beat = BW'(b);
        for (int j = 0; j < SIMD; j++) feat_data[j*DW +: DW] = DW'(feat[n][b*SIMD+j]);
        @(negedge clk);
      end
    feat_we = 0;
    for (int b = 0; b < BEATS; b++) begin
      bias_we = 1; bias_beat = BW'(b);
      for (int j = 0; j < SIMD; j++) bias_data[j*DW +: DW] = DW'(bias[b*SIMD+j]);
      @(negedge clk);
    end
    bias_we = 0;
  endtask

  task automatic send_edge(input int s, input int d, input int w);
    edge_valid = 1; edge_src = NIW'(s); edge_dst = NIW'(d); edge_wt = WW'(w);
    while (!edge_ready) @(negedge clk);
    if (n_acc == 0) first_acc = cyc;
    last_acc = cyc;
    n_acc++;
    @(negedge clk);
    edge_valid = 0;
  endtask

  // tag: label used for element checks ("" picks R2/R6/R10 per element)
  task automatic run_graph(input int rows, input string tag);
    int k;
    bit ready_seen;
    n_got = 0; n_acc = 0;
    for (int e = 0; e < ne; e++) send_edge(es[e], ed[e], ew[e]);
    graph_end = 1; graph_rows = RW'(rows);
    @(negedge clk);
    graph_end = 0;
    ready_seen = 0;
    k = 0;
    while (!(out_valid && out_last) && k < 300) begin
      if (edge_ready) ready_seen = 1;
      @(negedge clk);
      k++;
    end
    if (edge_ready) ready_seen = 1;
    check("R8", int'(ready_seen), 0, "edge_ready during drain");
    @(negedge clk);
    check("R4", n_got, rows*BEATS, "beats emitted");
    check("R3", last_acc - first_acc, (ne-1)*BEATS, "accept spacing");
    for (int r = 0; r < rows; r++)
      for (int f = 0; f < NF; f++) begin
        int sum, has, v, idx;
        string lab;
        sum = 0; has = 0;
        for (int e = 0; e < ne; e++)
          if (ed[e] == r) begin sum += ew[e] * feat[es[e]][f]; has = 1; end
        v = sum + bias[f];
        lab = (tag != "") ? tag : (has == 0) ? "R10" : (v < 0) ? "R6" : "R2";
        idx = r*BEATS + f/SIMD;
        if (idx < n_got) check(lab, got[idx][f%SIMD], (v < 0) ? 0 : v, $sformatf("row %0d feat %0d", r, f));
      end
    for (int i = 0; i < n_got; i++)
      check("R5", int'(got_last[i]), int'(i == rows*BEATS-1), $sformatf("last flag beat %0d", i));
  endtask

  task automatic rand_data();
    for (int n = 0; n < NN; n++) for (int f = 0; f < NF; f++) feat[n][f] = rnd(-128, 127);
    for (int f = 0; f < NF; f++) bias[f] = rnd(-128, 127);
  endtask

  initial begin
    int k;
    repeat (3) @(negedge clk);
    check("R1", int'(edge_ready), 0, "ready in reset");
    rst = 0;
    k = 0;
    while (!edge_ready && k < 100) begin
      check("R1", int'(out_valid), 0, "out_valid during clear");
      @(negedge clk);
      k++;
    end
    check("R1", k, DEPTH, "clear cycles");

    // directed graph: self loops, mixed signs, node 3 without edges
    rand_data();
    load_all();
    ne = 0;
    es[ne]=0; ed[ne]=0; ew[ne]=50;  ne++;
    es[ne]=1; ed[ne]=1; ew[ne]=-20; ne++;
    es[ne]=1; ed[ne]=0; ew[ne]=33;  ne++;
    es[ne]=2; ed[ne]=2; ew[ne]=127; ne++;
    es[ne]=0; ed[ne]=1; ew[ne]=-128; ne++;
    es[ne]=4; ed[ne]=4; ew[ne]=7;   ne++;
    run_graph(5, "");
    // same graph again: accumulators must restart from zero
    run_graph(5, "R7");

    // R9: same destination separated by a single other edge
    ne = 0;
    es[ne]=0; ed[ne]=2; ew[ne]=11;  ne++;
    es[ne]=1; ed[ne]=1; ew[ne]=-5;  ne++;
    es[ne]=2; ed[ne]=2; ew[ne]=9;   ne++;
    es[ne]=3; ed[ne]=1; ew[ne]=40;  ne++;
    es[ne]=4; ed[ne]=2; ew[ne]=-70; ne++;
    run_graph(3, "R9");

    // extreme magnitude: all -128 features and weights
    for (int n = 0; n < NN; n++) for (int f = 0; f < NF; f++) feat[n][f] = -128;
    for (int f = 0; f < NF; f++) bias[f] = 127;
    load_all();
    ne = 0;
    for (int i = 0; i < 12; i++) begin
      es[ne] = i % NN; ed[ne] = (i % 2) ? 5 : 4; ew[ne] = -128; ne++;
    end
    run_graph(6, "");

    // single node, single self loop
    rand_data();
    load_all();
    ne = 1; es[0] = 0; ed[0] = 0; ew[0] = -1;
    run_graph(1, "");

    // random sweep
    for (int g = 0; g < 40; g++) begin
      int rows, extra, prev;
      rows = rnd(1, NN);
      rand_data();
      load_all();
      ne = 0;
      for (int n = 0; n < rows; n++) begin es[ne] = n; ed[ne] = n; ew[ne] = rnd(-128, 127); ne++; end
      extra = (rows > 1) ? rnd(0, 8) : 0;
      prev = rows - 1;
      for (int i = 0; i < extra; i++) begin
        int d;
        d = rnd(0, rows - 1);
        if (d == prev) d = (d + 1) % rows;  // keep the R9 ordering contract
        es[ne] = rnd(0, NN - 1); ed[ne] = d; ew[ne] = rnd(-128, 127); ne++;
        prev = d;
      end
      run_graph(rows, "");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule